// File: doc/BRIEF.md
# Audio Clock Generator with Frame-Rate Detection

This block runs entirely from the master clock of a serial audio receiver. In master mode it divides the master clock to produce a bit clock at one quarter of the master rate and a frame clock at 1/256 of it. It also drives a gated copy of the master clock out of the block and raises output enables so that the generated clocks can be driven onto shared pins. The reported rate follows the double-speed select.

In slave mode the generated clocks and the master clock copy stay low. The block then watches an external bit clock and frame clock, which must be synchronous to the master clock but may have any phase relative to it. It counts master clocks and bit-clock rising edges between consecutive frame-clock rising edges. From these counts it classifies the stream as normal, double or quad speed. Quad speed is recognised automatically: it is the only case with 128 master clocks per frame, and it is accepted only while double speed is deselected. Any other count, or a frame clock that stops, raises a clock-error flag for a downstream status sequencer.

The master/slave and double-speed selects are captured while reset is held. Changing them at any other time has no effect.

Top module: `audio_clkgen`

## Requirements
- R1: In master mode `bclk_out` toggles every 2 master clocks (period 4, 50% duty) and `bclk_oe` is 1.
- R2: In master mode `fclk_out` toggles every 128 master clocks (period 256). Every `fclk_out` transition coincides with a falling edge of `bclk_out`, so there are 64 bit-clock rising edges per frame and `fclk_oe` is 1.
- R3: In master mode `mclk_out` is high while `clk` is high and low while `clk` is low. In slave mode, and while reset is held, `mclk_out`, `bclk_out`, `fclk_out`, `bclk_oe` and `fclk_oe` are all 0.
- R4: `master_sel` and `dbl_sel` are captured only while `rst_n` is low, up to the first clock edge after release. Later changes do not alter the mode or the outputs.
- R5: In master mode `rate` is 0 (normal) with `dbl_sel`=0 and 1 (double) with `dbl_sel`=1; `rate_valid` is 1 and `clk_err` is 0.
- R6: In slave mode, a frame of 256 master clocks containing 64 bit-clock rising edges sets `rate_valid`=1 and `clk_err`=0. `rate` becomes 0 (normal) with `dbl_sel`=0 and 1 (double) with `dbl_sel`=1.
- R7: In slave mode, a frame of 128 master clocks with 64 bit-clock rising edges reports `rate`=2 (quad) only when `dbl_sel`=0. With `dbl_sel`=1 it is a clock error.
- R8: In slave mode, a frame with any other master-clock count, or with a bit-clock count other than 64, sets `clk_err`=1 and `rate_valid`=0.
- R9: In slave mode, if no frame-clock rising edge is seen for TIMEOUT master clocks (default 1024), `clk_err` is set and `rate_valid` is cleared. This does not happen earlier.
- R10: After reset `rate_valid` and `clk_err` are 0. The first frame edge only arms the detector. A later correctly measured frame clears `clk_err` and sets `rate_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_sel | input | 1 | 1 = generate clocks, 0 = accept external clocks |
| dbl_sel | input | 1 | Double-speed select |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_fclk | input | 1 | External frame clock (slave mode) |
| mclk_out | output | 1 | Gated master clock copy (master mode) |
| bclk_out | output | 1 | Generated bit clock |
| fclk_out | output | 1 | Generated frame clock |
| bclk_oe | output | 1 | Output enable for the bit clock |
| fclk_oe | output | 1 | Output enable for the frame clock |
| rate | output | 2 | 0 normal, 1 double, 2 quad |
| rate_valid | output | 1 | Rate indication is trustworthy |
| clk_err | output | 1 | Frame lock lost or frame clock absent |

## Verification
The hardest condition to reach is the boundary of the frame-clock timeout. The flag must stay low just short of TIMEOUT cycles after the last frame edge and be high just past it. The stimulus reaches this by first locking on good frames, then holding the frame clock low. The flag is sampled 956 and about 1156 cycles after the last edge. Recovery from an error is reached by sending malformed frames, then good ones. Two good frames are needed, because the first good edge still closes a bad interval.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;

  typedef enum logic [1:0] {
    RATE_NORMAL = 2'd0,
    RATE_DOUBLE = 2'd1,
    RATE_QUAD   = 2'd2
  } rate_e;

  typedef struct packed {
    logic  ok;
    rate_e rate;
  } rate_verdict_t;

  // Judge one measured frame: master clocks per frame and bit-clock rises per frame.
  function automatic rate_verdict_t classify_frame(
    input int unsigned mclks,
    input int unsigned bits,
    input logic        dbl,
    input int unsigned full_div,
    input int unsigned quad_div,
    input int unsigned bits_per_frame
  );
    rate_verdict_t v;
    v.ok   = 1'b0;
    v.rate = RATE_NORMAL;
    if (bits == bits_per_frame) begin
      if (mclks == full_div) begin
        v.ok   = 1'b1;
        v.rate = dbl ? RATE_DOUBLE : RATE_NORMAL;
      end else if (mclks == quad_div && !dbl) begin
        v.ok   = 1'b1;
        v.rate = RATE_QUAD;
      end
    end
    return v;
  endfunction

endpackage

// File: rtl/aclk_divider.sv
module aclk_divider #(
  parameter int unsigned FRAME_DIV = 256,
  parameter int unsigned BIT_DIV   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bclk,
  output logic fclk
);
  localparam int unsigned CW = $clog2(FRAME_DIV);
  localparam int unsigned BB = $clog2(BIT_DIV) - 1;

  logic [CW-1:0] cnt;

  // One shared counter keeps the bit and frame edges aligned.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= cnt + CW'(1);
    else         cnt <= '0;
  end

  assign bclk = en & cnt[BB];
  assign fclk = en & cnt[CW-1];
endmodule

// File: rtl/aclk_rate_det.sv
module aclk_rate_det
  import audio_clk_pkg::*;
#(
  parameter int unsigned FULL_DIV       = 256,
  parameter int unsigned QUAD_DIV       = 128,
  parameter int unsigned BITS_PER_FRAME = 64,
  parameter int unsigned TIMEOUT        = 1024
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  dbl,
  input  logic  ext_bclk,
  input  logic  ext_fclk,
  output logic  f_rise,
  output rate_e rate,
  output logic  valid,
  output logic  err
);
  localparam int unsigned PW = $clog2(TIMEOUT);
  localparam int unsigned BW = $clog2(BITS_PER_FRAME) + 2;

  logic [1:0]    fsh, bsh;
  logic          b_rise, armed, timed_out;
  logic [PW-1:0] per_cnt;
  logic [BW-1:0] bit_cnt;
  rate_verdict_t verdict;

  assign f_rise    = fsh[0] & ~fsh[1];
  assign b_rise    = bsh[0] & ~bsh[1];
  assign timed_out = (per_cnt == PW'(TIMEOUT - 1));

  always_comb
    verdict = classify_frame(32'(per_cnt) + 32'd1,
                             32'(bit_cnt) + (b_rise ? 32'd1 : 32'd0),
                             dbl, FULL_DIV, QUAD_DIV, BITS_PER_FRAME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsh <= '0; bsh <= '0; armed <= 1'b0;
      per_cnt <= '0; bit_cnt <= '0;
      rate <= RATE_NORMAL; valid <= 1'b0; err <= 1'b0;
    end else if (!en) begin
      fsh <= '0; bsh <= '0; armed <= 1'b0;
      per_cnt <= '0; bit_cnt <= '0;
      rate <= RATE_NORMAL; valid <= 1'b0; err <= 1'b0;
    end else begin
      fsh <= {fsh[0], ext_fclk};
      bsh <= {bsh[0], ext_bclk};
      if (f_rise) begin
        if (armed) begin
          if (verdict.ok) begin
            valid <= 1'b1; err <= 1'b0; rate <= verdict.rate;
          end else begin
            valid <= 1'b0; err <= 1'b1;
          end
        end
        armed   <= 1'b1;
        per_cnt <= '0;
        bit_cnt <= '0;
      end else if (timed_out) begin
        valid <= 1'b0;
        err   <= 1'b1;
        armed <= 1'b0;
      end else begin
        per_cnt <= per_cnt + PW'(1);
        if (b_rise && bit_cnt != '1) bit_cnt <= bit_cnt + BW'(1);
      end
    end
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clk_pkg::*;
#(
  parameter int unsigned FRAME_DIV = 256,
  parameter int unsigned BIT_DIV   = 4,
  parameter int unsigned TIMEOUT   = 4 * FRAME_DIV
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_sel,
  input  logic       dbl_sel,
  input  logic       ext_bclk,
  input  logic       ext_fclk,
  output logic       mclk_out,
  output logic       bclk_out,
  output logic       fclk_out,
  output logic       bclk_oe,
  output logic       fclk_oe,
  output logic [1:0] rate,
  output logic       rate_valid,
  output logic       clk_err
);
  localparam int unsigned QUAD_DIV       = FRAME_DIV / 2;
  localparam int unsigned BITS_PER_FRAME = FRAME_DIV / BIT_DIV;

  logic  running, master_q, dbl_q, mgate_q;
  logic  gen_en, det_en, f_rise;
  logic  det_valid, det_err;
  rate_e det_rate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= 1'b1;
  end

  // Mode selects are loaded only while the block is held idle.
  always_ff @(posedge clk) begin
    if (!running) begin
      master_q <= master_sel;
      dbl_q    <= dbl_sel;
    end
  end

  // Gate enable changes on the low phase so mclk_out never carries a runt.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) mgate_q <= 1'b0;
    else        mgate_q <= running & master_q;
  end

  assign gen_en = running & master_q;
  assign det_en = running & ~master_q;

  aclk_divider #(.FRAME_DIV(FRAME_DIV), .BIT_DIV(BIT_DIV)) i_div (
    .clk(clk), .rst_n(rst_n), .en(gen_en), .bclk(bclk_out), .fclk(fclk_out)
  );

  aclk_rate_det #(
    .FULL_DIV(FRAME_DIV), .QUAD_DIV(QUAD_DIV),
    .BITS_PER_FRAME(BITS_PER_FRAME), .TIMEOUT(TIMEOUT)
  ) i_det (
    .clk(clk), .rst_n(rst_n), .en(det_en), .dbl(dbl_q),
    .ext_bclk(ext_bclk), .ext_fclk(ext_fclk), .f_rise(f_rise),
    .rate(det_rate), .valid(det_valid), .err(det_err)
  );

  assign mclk_out   = clk & mgate_q;
  assign bclk_oe    = gen_en;
  assign fclk_oe    = gen_en;
  assign rate       = master_q ? (dbl_q ? RATE_DOUBLE : RATE_NORMAL) : det_rate;
  assign rate_valid = running & (master_q | det_valid);
  assign clk_err    = running & ~master_q & det_err;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
  parameter int unsigned TIMEOUT = 1024
) (
  input logic       clk,
  input logic       rst_n,
  input logic       running,
  input logic       master_q,
  input logic       dbl_q,
  input logic       f_rise,
  input logic       bclk_out,
  input logic       fclk_out,
  input logic       bclk_oe,
  input logic [1:0] rate,
  input logic       rate_valid,
  input logic       clk_err
);
  localparam int unsigned IW = $clog2(TIMEOUT) + 2;
  logic [IW-1:0] idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                idle <= '0;
    else if (!(running && !master_q) || f_rise) idle <= '0;
    else if (idle != '1)                       idle <= idle + IW'(1);
  end

  assert_bclk_half_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && master_q && !$stable(bclk_out)) |=> $stable(bclk_out));

  assert_frame_on_bit_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && master_q && !$stable(fclk_out)) |-> $fell(bclk_out));

  assert_quiet_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_oe |-> (!bclk_out && !fclk_out));

  assert_mode_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> ($stable(master_q) && $stable(dbl_q)));

  assert_master_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && master_q) |-> (rate_valid && !clk_err));

  assert_quad_needs_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_valid && rate == 2'd2) |-> !dbl_q);

  assert_err_excludes_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_err |-> !rate_valid);

  assert_timeout_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(idle) > TIMEOUT) |-> clk_err);
endmodule

bind audio_clkgen audio_clkgen_chk #(.TIMEOUT(TIMEOUT)) i_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .master_q(master_q),
  .dbl_q(dbl_q), .f_rise(f_rise), .bclk_out(bclk_out), .fclk_out(fclk_out),
  .bclk_oe(bclk_oe), .rate(rate), .rate_valid(rate_valid), .clk_err(clk_err)
);

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_sel = 1'b0, dbl_sel = 1'b0, ext_bclk = 1'b0, ext_fclk = 1'b0;
  logic mclk_out, bclk_out, fclk_out, bclk_oe, fclk_oe, rate_valid, clk_err;
  logic [1:0] rate;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  audio_clkgen i_audio_clkgen (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .dbl_sel(dbl_sel),
    .ext_bclk(ext_bclk), .ext_fclk(ext_fclk), .mclk_out(mclk_out),
    .bclk_out(bclk_out), .fclk_out(fclk_out), .bclk_oe(bclk_oe),
    .fclk_oe(fclk_oe), .rate(rate), .rate_valid(rate_valid), .clk_err(clk_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_reset(input logic ms, input logic dbl);
    rst_n = 1'b0; master_sel = ms; dbl_sel = dbl; ext_bclk = 0; ext_fclk = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic drive_frames(input int n, input int period, input int bdiv);
    for (int f = 0; f < n; f++)
      for (int p = 0; p < period; p++) begin
        @(negedge clk);
        ext_fclk = (p < period / 2);
        ext_bclk = ((p % bdiv) >= (bdiv / 2));
      end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; master_sel = 1'b1; dbl_sel = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!bclk_oe && !fclk_oe && !bclk_out && !fclk_out, "R3 reset outputs",
          {bclk_oe, fclk_oe, bclk_out, fclk_out}, 0);
    check(!rate_valid && !clk_err, "R10 reset status", {rate_valid, clk_err}, 0);
  endtask

  task automatic t_master(input logic dbl);
    int last_bt = -1, last_ft = -1, last_fr = -1, bits = 0;
    int bad_b = 0, bad_f = 0, bad_align = 0, bad_bits = 0, bad_stat = 0, bad_m = 0;
    logic pb = 0, pf = 0;
    apply_reset(1'b1, dbl);
    for (int i = 0; i < 1100; i++) begin
      @(posedge clk); #2;
      if (mclk_out !== 1'b1) bad_m++;
      @(negedge clk); #1;
      if (mclk_out !== 1'b0) bad_m++;
      if (bclk_out != pb) begin
        if (last_bt >= 0 && i - last_bt != 2) bad_b++;
        last_bt = i;
        if (bclk_out) bits++;
      end
      if (fclk_out != pf) begin
        if (last_ft >= 0 && i - last_ft != 128) bad_f++;
        last_ft = i;
        if (!(pb && !bclk_out)) bad_align++;
        if (fclk_out) begin
          if (last_fr >= 0 && bits != 64) bad_bits++;
          last_fr = i; bits = 0;
        end
      end
      if (!bclk_oe || !fclk_oe || !rate_valid || clk_err || rate != {1'b0, dbl}) bad_stat++;
      pb = bclk_out; pf = fclk_out;
    end
    check(bad_b == 0 && last_bt >= 0, "R1 bclk half period", bad_b, 0);
    check(bad_f == 0 && last_ft >= 0, "R2 fclk half period", bad_f, 0);
    check(bad_align == 0, "R2 fclk on bclk fall", bad_align, 0);
    check(bad_bits == 0 && last_fr >= 0, "R2 bits per frame", bad_bits, 0);
    check(bad_m == 0, "R3 mclk_out follows clk", bad_m, 0);
    check(bad_stat == 0, "R5 master status", bad_stat, 0);
  endtask

  task automatic t_mode_hold();
    int rises = 0;
    logic pf = 0;
    apply_reset(1'b1, 1'b0);
    master_sel = 1'b0; dbl_sel = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #1;
      if (fclk_out && !pf) rises++;
      pf = fclk_out;
    end
    check(bclk_oe && fclk_oe, "R4 oe kept", {bclk_oe, fclk_oe}, 3);
    check(rises >= 2, "R4 generation kept", rises, 2);
    check(rate == 2'd0, "R4 rate kept", rate, 0);
  endtask

  task automatic t_slave_quiet();
    int bad = 0;
    apply_reset(1'b0, 1'b0);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #2;
      if (mclk_out || bclk_out || fclk_out || bclk_oe || fclk_oe) bad++;
    end
    check(bad == 0, "R3 slave outputs low", bad, 0);
    check(!rate_valid && !clk_err, "R10 idle after reset", {rate_valid, clk_err}, 0);
  endtask

  task automatic t_slave_rate(input logic dbl, input int period, input int bdiv,
                              input bit exp_ok, input int exp_rate, input string tag);
    apply_reset(1'b0, dbl);
    drive_frames(4, period, bdiv);
    @(negedge clk); #1;
    check(rate_valid == exp_ok, {tag, " valid"}, rate_valid, exp_ok);
    check(clk_err == !exp_ok, {tag, " err"}, clk_err, !exp_ok);
    if (exp_ok) check(rate == exp_rate, {tag, " rate"}, rate, exp_rate);
  endtask

  task automatic t_arm_only();
    apply_reset(1'b0, 1'b0);
    drive_frames(1, 256, 4);
    @(negedge clk); #1;
    check(!rate_valid && !clk_err, "R10 first edge arms only", {rate_valid, clk_err}, 0);
  endtask

  task automatic t_recovery();
    apply_reset(1'b0, 1'b0);
    drive_frames(3, 192, 3);
    @(negedge clk); #1;
    check(clk_err && !rate_valid, "R8 bad period", {clk_err, rate_valid}, 2);
    drive_frames(3, 256, 4);
    @(negedge clk); #1;
    check(!clk_err && rate_valid && rate == 2'd0, "R10 recovery",
          {clk_err, rate_valid, rate}, 4);
  endtask

  task automatic t_timeout();
    apply_reset(1'b0, 1'b0);
    drive_frames(3, 256, 4);
    repeat (700) @(negedge clk);
    #1;
    check(!clk_err && rate_valid, "R9 no early timeout", {clk_err, rate_valid}, 1);
    repeat (200) @(negedge clk);
    #1;
    check(clk_err && !rate_valid, "R9 timeout flagged", {clk_err, rate_valid}, 2);
  endtask

  initial begin
    t_reset_state();
    t_master(1'b0);
    t_master(1'b1);
    t_mode_hold();
    t_slave_quiet();
    t_arm_only();
    t_slave_rate(1'b0, 256, 4, 1, 0, "R6 normal");
    t_slave_rate(1'b1, 256, 4, 1, 1, "R6 double");
    t_slave_rate(1'b0, 128, 2, 1, 2, "R7 quad");
    t_slave_rate(1'b1, 128, 2, 0, 0, "R7 quad with double");
    t_slave_rate(1'b0, 192, 3, 0, 0, "R8 period 192");
    t_slave_rate(1'b0, 256, 8, 0, 0, "R8 32 bits");
    t_recovery();
    t_timeout();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule